// File: doc/BRIEF.md
# Integer Outer Product Tile Unit

This unit performs one integer outer-product step over a square tile of 64-bit accumulator words. Each tile cell sits at a row index r and a column index c. The unit reads the cell and computes a packed dot product of row word r of the row operand vector with column word c of the column operand vector. It then adds that dot product to the cell, or subtracts it, and writes the cell back. Two element sizes are supported. In narrow mode each 64-bit word holds two 32-bit accumulators, fed by 8-bit lanes. In wide mode the whole word is one 64-bit accumulator, fed by 16-bit lanes. The signedness of the row operand and of the column operand is chosen separately.

Per-byte predicates for the row vector and the column vector gate which lanes take part. A lane that is switched off contributes zero, but the cell is still rewritten.

The tile itself lives outside the unit and is reached through a read-modify-write port. The memory must return read data one cycle after a read request. The unit walks the tile in row-major order, one cell per cycle, and pulses `done` when the last cell has been written. The parameter `WORDS` sets both the number of 64-bit words per operand vector and the tile edge length.

Top module: `sop_tile_unit`

## Requirements
- R1: While reset is applied and after it is released, `busy`, `done`, `tile_rd_en` and `tile_wr_en` are low until a start is accepted.
- R2: A `start` sampled while idle is accepted. From the next cycle on, `busy` and `tile_rd_en` are high for exactly WORDS*WORDS cycles, with `tile_rd_addr` stepping 0, 1, 2, … where address = r*WORDS + c (row-major order).
- R3: Each cell is written exactly once, one cycle after its read, to the same address and in the same order.
- R4: In narrow mode (`mode_wide`=0), bits [31:0] of a word take the products of byte lanes 0–3 and bits [63:32] take those of byte lanes 4–7. Byte lane b is bits [8b+7:8b], and each lane product is the row byte times the column byte of the same lane.
- R5: Lane enable for byte b of cell (r,c) is `row_pred[8r+b] & col_pred[8c+b]`. A disabled lane has its row byte zeroed before multiplying.
- R6: `mode_row_signed` and `mode_col_signed` independently select two's-complement (1) or unsigned (0) interpretation of the row and column lanes.
- R7: With `mode_negate`=1 the dot product is subtracted from each accumulator instead of added.
- R8: In wide mode (`mode_wide`=1), 16-bit lane j is bits [16j+15:16j]. Its enable is the combined predicate bit of byte 2j, and the four lane products are summed into the full 64-bit word.
- R9: Accumulation wraps modulo 2^32 per narrow accumulator, with no carry between the two halves, and modulo 2^64 in wide mode.
- R10: A cell whose lanes are all disabled is still written, with its value unchanged.
- R11: `done` is high for exactly one cycle, the cycle after the last cell write.
- R12: `start` while busy is ignored. The mode inputs are captured when a start is accepted, and later changes have no effect on the running pass.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a pass over the tile |
| mode_row_signed | input | 1 | Row operand lanes are signed |
| mode_col_signed | input | 1 | Column operand lanes are signed |
| mode_negate | input | 1 | Subtract instead of add |
| mode_wide | input | 1 | 0: 8-bit into 32-bit, 1: 16-bit into 64-bit |
| row_vec | input | WORDS*64 | Row operand vector, word r at bits [64r+63:64r] |
| col_vec | input | WORDS*64 | Column operand vector |
| row_pred | input | WORDS*8 | Row predicate, one bit per byte |
| col_pred | input | WORDS*8 | Column predicate, one bit per byte |
| busy | output | 1 | Pass in progress (read phase) |
| done | output | 1 | One-cycle pulse after the last write |
| tile_rd_en | output | 1 | Tile read request |
| tile_rd_addr | output | clog2(WORDS*WORDS) | Tile read address |
| tile_rd_data | input | 64 | Tile read data, valid one cycle after the request |
| tile_wr_en | output | 1 | Tile write strobe |
| tile_wr_addr | output | clog2(WORDS*WORDS) | Tile write address |
| tile_wr_data | output | 64 | Tile write data |

## Verification
The properties assume that the tile memory answers a read on the following cycle. They also assume that the operand vectors and predicates stay constant from the accepted start until `done`. The check that an all-disabled cell is written back unchanged reads the predicates at write time, so it depends on that second assumption. The stimulus changes vectors, predicates and tile contents only while the unit is idle. Only the mode inputs and `start` are disturbed in the middle of a pass, and those are required to be ignored. The bench supplies a memory with exactly one cycle of read latency.

// File: rtl/sop_pkg.sv
package sop_pkg;
  localparam int WORD_W  = 64;
  localparam int BYTE_W  = 8;
  localparam int NBYTES  = WORD_W / BYTE_W;
  localparam int HALF_W  = WORD_W / 2;
  localparam int HWORD_W = 16;
  localparam int NHW     = WORD_W / HWORD_W;
  localparam int BPH     = NBYTES / 2;

  typedef struct packed {
    logic row_signed;
    logic col_signed;
    logic negate;
    logic wide;
  } sop_mode_t;
endpackage

// File: rtl/sop_walker.sv
module sop_walker #(
  parameter int WORDS = 4,
  localparam int RW = (WORDS > 1) ? $clog2(WORDS) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  output logic          busy,
  output logic          accept,
  output logic [RW-1:0] issue_row,
  output logic [RW-1:0] issue_col,
  output logic          stg_vld,
  output logic [RW-1:0] stg_row,
  output logic [RW-1:0] stg_col,
  output logic          done
);
  logic          busy_q, busy_d;
  logic [RW-1:0] row_q, row_d, col_q, col_d;
  logic          vld_q, vld_d, last_q, last_d, done_q, done_d;
  logic [RW-1:0] srow_q, scol_q;
  logic          col_last, row_last, walk_en;

  assign col_last = (col_q == RW'(WORDS - 1));
  assign row_last = (row_q == RW'(WORDS - 1));
  assign accept   = start & ~busy_q;
  assign walk_en  = busy_q | start;

  always_comb begin
    busy_d = busy_q;
    row_d  = row_q;
    col_d  = col_q;
    if (busy_q) begin
      if (col_last) begin
        col_d = '0;
        if (row_last) busy_d = 1'b0;
        else          row_d  = row_q + 1'b1;
      end else begin
        col_d = col_q + 1'b1;
      end
    end else if (start) begin
      busy_d = 1'b1;
      row_d  = '0;
      col_d  = '0;
    end
    vld_d  = busy_q;
    last_d = busy_q & col_last & row_last;
    done_d = vld_q & last_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      row_q  <= '0;
      col_q  <= '0;
      vld_q  <= 1'b0;
      last_q <= 1'b0;
      done_q <= 1'b0;
      srow_q <= '0;
      scol_q <= '0;
    end else begin
      busy_q <= busy_d;
      vld_q  <= vld_d;
      last_q <= last_d;
      done_q <= done_d;
      if (walk_en) begin
        row_q <= row_d;
        col_q <= col_d;
      end
      if (busy_q) begin
        srow_q <= row_q;
        scol_q <= col_q;
      end
    end
  end

  assign busy      = busy_q;
  assign issue_row = row_q;
  assign issue_col = col_q;
  assign stg_vld   = vld_q;
  assign stg_row   = srow_q;
  assign stg_col   = scol_q;
  assign done      = done_q;
endmodule

// File: rtl/sop_lane_mask.sv
module sop_lane_mask import sop_pkg::*; (
  input  logic [NBYTES-1:0] row_pg,
  input  logic [NBYTES-1:0] col_pg,
  input  logic              wide,
  output logic [NBYTES-1:0] lane_en
);
  logic [NBYTES-1:0] both;
  assign both = row_pg & col_pg;

  for (genvar b = 0; b < NBYTES; b++) begin : g_byte
    // wide lanes take the enable of their lower byte
    assign lane_en[b] = wide ? both[(b / 2) * 2] : both[b];
  end
endmodule

// File: rtl/sop_dot_cell.sv
module sop_dot_cell import sop_pkg::*; (
  input  logic [WORD_W-1:0] row_word,
  input  logic [WORD_W-1:0] col_word,
  input  logic [NBYTES-1:0] lane_en,
  input  sop_mode_t         mode,
  input  logic [WORD_W-1:0] acc,
  output logic [WORD_W-1:0] result
);
  localparam int BP_W = 2 * (BYTE_W + 1);
  localparam int BS_W = BP_W + 2;
  localparam int HP_W = 2 * (HWORD_W + 1);
  localparam int HS_W = HP_W + 2;

  logic [WORD_W-1:0] row_m;
  logic signed [BP_W-1:0] bprod [NBYTES];
  logic signed [HP_W-1:0] hprod [NHW];
  logic signed [BS_W-1:0] bsum  [2];
  logic signed [HS_W-1:0] hsum;
  logic [WORD_W-1:0] narrow_res, wide_res;

  for (genvar b = 0; b < NBYTES; b++) begin : g_mask
    assign row_m[b*BYTE_W +: BYTE_W] = row_word[b*BYTE_W +: BYTE_W] & {BYTE_W{lane_en[b]}};
  end

  for (genvar b = 0; b < NBYTES; b++) begin : g_bprod
    assign bprod[b] =
      $signed({mode.row_signed & row_m[b*BYTE_W+BYTE_W-1], row_m[b*BYTE_W +: BYTE_W]}) *
      $signed({mode.col_signed & col_word[b*BYTE_W+BYTE_W-1], col_word[b*BYTE_W +: BYTE_W]});
  end

  for (genvar j = 0; j < NHW; j++) begin : g_hprod
    assign hprod[j] =
      $signed({mode.row_signed & row_m[j*HWORD_W+HWORD_W-1], row_m[j*HWORD_W +: HWORD_W]}) *
      $signed({mode.col_signed & col_word[j*HWORD_W+HWORD_W-1], col_word[j*HWORD_W +: HWORD_W]});
  end

  always_comb begin
    for (int h = 0; h < 2; h++) begin
      bsum[h] = '0;
      for (int j = 0; j < BPH; j++) begin
        bsum[h] = bsum[h] + BS_W'(bprod[h*BPH + j]);
      end
    end
    hsum = '0;
    for (int j = 0; j < NHW; j++) begin
      hsum = hsum + HS_W'(hprod[j]);
    end
  end

  for (genvar h = 0; h < 2; h++) begin : g_half
    assign narrow_res[h*HALF_W +: HALF_W] = mode.negate ?
      acc[h*HALF_W +: HALF_W] - HALF_W'(bsum[h]) :
      acc[h*HALF_W +: HALF_W] + HALF_W'(bsum[h]);
  end

  assign wide_res = mode.negate ? acc - WORD_W'(hsum) : acc + WORD_W'(hsum);
  assign result   = mode.wide ? wide_res : narrow_res;
endmodule

// File: rtl/sop_tile_unit.sv
module sop_tile_unit import sop_pkg::*; #(
  parameter int WORDS = 4,
  localparam int RW = (WORDS > 1) ? $clog2(WORDS) : 1,
  localparam int AW = (WORDS > 1) ? $clog2(WORDS * WORDS) : 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    start,
  input  logic                    mode_row_signed,
  input  logic                    mode_col_signed,
  input  logic                    mode_negate,
  input  logic                    mode_wide,
  input  logic [WORDS*WORD_W-1:0] row_vec,
  input  logic [WORDS*WORD_W-1:0] col_vec,
  input  logic [WORDS*NBYTES-1:0] row_pred,
  input  logic [WORDS*NBYTES-1:0] col_pred,
  output logic                    busy,
  output logic                    done,
  output logic                    tile_rd_en,
  output logic [AW-1:0]           tile_rd_addr,
  input  logic [WORD_W-1:0]       tile_rd_data,
  output logic                    tile_wr_en,
  output logic [AW-1:0]           tile_wr_addr,
  output logic [WORD_W-1:0]       tile_wr_data
);
  logic [1:0]    rst_sync_q;
  logic          rst_int_n;
  logic          accept, stg_vld;
  logic [RW-1:0] issue_row, issue_col, stg_row, stg_col;
  sop_mode_t     mode_in, mode_q;
  logic [NBYTES-1:0] lane_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  assign mode_in = '{row_signed: mode_row_signed, col_signed: mode_col_signed,
                     negate: mode_negate, wide: mode_wide};

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n)  mode_q <= '0;
    else if (accept) mode_q <= mode_in;
  end

  sop_walker #(.WORDS(WORDS)) u_walk (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .start     (start),
    .busy      (busy),
    .accept    (accept),
    .issue_row (issue_row),
    .issue_col (issue_col),
    .stg_vld   (stg_vld),
    .stg_row   (stg_row),
    .stg_col   (stg_col),
    .done      (done)
  );

  sop_lane_mask u_mask (
    .row_pg  (row_pred[stg_row*NBYTES +: NBYTES]),
    .col_pg  (col_pred[stg_col*NBYTES +: NBYTES]),
    .wide    (mode_q.wide),
    .lane_en (lane_en)
  );

  sop_dot_cell u_cell (
    .row_word (row_vec[stg_row*WORD_W +: WORD_W]),
    .col_word (col_vec[stg_col*WORD_W +: WORD_W]),
    .lane_en  (lane_en),
    .mode     (mode_q),
    .acc      (tile_rd_data),
    .result   (tile_wr_data)
  );

  assign tile_rd_en   = busy;
  assign tile_rd_addr = AW'(issue_row) * AW'(WORDS) + AW'(issue_col);
  assign tile_wr_en   = stg_vld;
  assign tile_wr_addr = AW'(stg_row) * AW'(WORDS) + AW'(stg_col);
endmodule

// File: rtl/sop_tile_unit_chk.sv
module sop_tile_unit_chk #(
  parameter int WORDS = 4,
  localparam int AW = (WORDS > 1) ? $clog2(WORDS * WORDS) : 1
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 start,
  input logic                 busy,
  input logic                 done,
  input logic                 tile_rd_en,
  input logic [AW-1:0]        tile_rd_addr,
  input logic [63:0]          tile_rd_data,
  input logic                 tile_wr_en,
  input logic [AW-1:0]        tile_wr_addr,
  input logic [63:0]          tile_wr_data,
  input logic [WORDS*8-1:0]   row_pred,
  input logic [WORDS*8-1:0]   col_pred
);
  int         wr_r, wr_c;
  logic [7:0] cell_pg;

  always_comb begin
    wr_r    = int'(tile_wr_addr) / WORDS;
    wr_c    = int'(tile_wr_addr) % WORDS;
    cell_pg = row_pred[wr_r*8 +: 8] & col_pred[wr_c*8 +: 8];
  end

  // R3
  wr_follows_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tile_wr_en |-> ($past(tile_rd_en) && tile_wr_addr == $past(tile_rd_addr)));

  // R2
  rd_addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tile_rd_en && $past(tile_rd_en)) |-> tile_rd_addr == AW'($past(tile_rd_addr) + 1'b1));

  // R2
  rd_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tile_rd_en && !$past(tile_rd_en)) |-> tile_rd_addr == '0);

  // R11
  done_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ($past(tile_wr_en) && !tile_wr_en && $past(tile_wr_addr) == AW'(WORDS*WORDS - 1)));

  // R11
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R12
  busy_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(start));

  // R10
  idle_cell_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tile_wr_en && cell_pg == 8'h00) |-> tile_wr_data == tile_rd_data);
endmodule

bind sop_tile_unit sop_tile_unit_chk #(.WORDS(WORDS)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .start        (start),
  .busy         (busy),
  .done         (done),
  .tile_rd_en   (tile_rd_en),
  .tile_rd_addr (tile_rd_addr),
  .tile_rd_data (tile_rd_data),
  .tile_wr_en   (tile_wr_en),
  .tile_wr_addr (tile_wr_addr),
  .tile_wr_data (tile_wr_data),
  .row_pred     (row_pred),
  .col_pred     (col_pred)
);

// File: tb/sim_sop_tile_unit.sv
module sim_sop_tile_unit;
  localparam int CLK_PERIOD = 10;
  localparam int WORDS = 4;
  localparam int NN = WORDS * WORDS;
  localparam int AW = $clog2(NN);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic mode_row_signed = 1'b0, mode_col_signed = 1'b0, mode_negate = 1'b0, mode_wide = 1'b0;
  logic [WORDS*64-1:0] row_vec = '0, col_vec = '0;
  logic [WORDS*8-1:0]  row_pred = '0, col_pred = '0;
  logic busy, done, tile_rd_en, tile_wr_en;
  logic [AW-1:0] tile_rd_addr, tile_wr_addr;
  logic [63:0] tile_rd_data, tile_wr_data;

  logic [63:0] mem [NN];
  logic [63:0] ref_tile [NN];
  int checks = 0, errors = 0;
  int cyc = 0, base = -1000;
  bit m_rs, m_cs, m_ng, m_wd;
  string cur_tag = "R4";

  always #(CLK_PERIOD/2) clk = ~clk;

  sop_tile_unit #(.WORDS(WORDS)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start),
    .mode_row_signed(mode_row_signed), .mode_col_signed(mode_col_signed),
    .mode_negate(mode_negate), .mode_wide(mode_wide),
    .row_vec(row_vec), .col_vec(col_vec), .row_pred(row_pred), .col_pred(col_pred),
    .busy(busy), .done(done),
    .tile_rd_en(tile_rd_en), .tile_rd_addr(tile_rd_addr), .tile_rd_data(tile_rd_data),
    .tile_wr_en(tile_wr_en), .tile_wr_addr(tile_wr_addr), .tile_wr_data(tile_wr_data)
  );

  // tile memory, one cycle read latency
  always @(posedge clk) begin
    if (tile_rd_en) tile_rd_data <= mem[tile_rd_addr];
    if (tile_wr_en) mem[tile_wr_addr] <= tile_wr_data;
  end

  task automatic check(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [63:0] ref_cell(input logic [63:0] acc, input logic [63:0] n,
      input logic [63:0] m, input logic [7:0] p, input bit rs, input bit cs, input bit ng, input bit wd);
    logic [63:0] r;
    longint s, a, b;
    r = '0;
    if (!wd) begin
      for (int h = 0; h < 2; h++) begin
        s = 0;
        for (int j = 0; j < 4; j++) begin
          int k = 4*h + j;
          a = !p[k] ? 0 : (rs ? longint'($signed(n[8*k +: 8])) : longint'(n[8*k +: 8]));
          b = cs ? longint'($signed(m[8*k +: 8])) : longint'(m[8*k +: 8]);
          s = s + a*b;
        end
        r[32*h +: 32] = ng ? acc[32*h +: 32] - 32'(s) : acc[32*h +: 32] + 32'(s);
      end
    end else begin
      s = 0;
      for (int j = 0; j < 4; j++) begin
        a = !p[2*j] ? 0 : (rs ? longint'($signed(n[16*j +: 16])) : longint'(n[16*j +: 16]));
        b = cs ? longint'($signed(m[16*j +: 16])) : longint'(m[16*j +: 16]);
        s = s + a*b;
      end
      r = ng ? acc - 64'(s) : acc + 64'(s);
    end
    return r;
  endfunction

  // behavioural model: acceptance and timing
  always @(posedge clk) begin
    if (!rst_n) begin
      cyc = 0;
      base = -1000;
    end else begin
      if (start && !((cyc - base) >= 0 && (cyc - base) <= NN-1)) begin
        base = cyc + 1;
        m_rs = mode_row_signed; m_cs = mode_col_signed;
        m_ng = mode_negate;     m_wd = mode_wide;
      end
      cyc = cyc + 1;
    end
  end

  // per-cycle comparison
  always @(negedge clk) begin
    if (rst_n) begin
      int d;
      bit eb, ew;
      d  = cyc - base;
      eb = (d >= 0 && d <= NN-1);
      ew = (d >= 1 && d <= NN);
      check("R2", "busy", 64'(busy), 64'(eb));
      check("R2", "tile_rd_en", 64'(tile_rd_en), 64'(eb));
      if (eb) check("R2", "tile_rd_addr", 64'(tile_rd_addr), 64'(d));
      check("R3", "tile_wr_en", 64'(tile_wr_en), 64'(ew));
      check("R11", "done", 64'(done), 64'(d == NN+1));
      if (ew) begin
        int ad, r, c;
        logic [63:0] e;
        ad = d - 1;
        r  = ad / WORDS;
        c  = ad % WORDS;
        e  = ref_cell(ref_tile[ad], row_vec[64*r +: 64], col_vec[64*c +: 64],
                      row_pred[8*r +: 8] & col_pred[8*c +: 8], m_rs, m_cs, m_ng, m_wd);
        check("R3", "tile_wr_addr", 64'(tile_wr_addr), 64'(ad));
        check(cur_tag, "tile_wr_data", tile_wr_data, e);
        ref_tile[ad] = e;
      end
    end
  end

  task automatic load_tile(input logic [63:0] fill, input bit rnd);
    for (int a = 0; a < NN; a++) begin
      logic [63:0] v;
      v = rnd ? {$urandom, $urandom} : fill;
      mem[a] = v;
      ref_tile[a] = v;
    end
  endtask

  task automatic rand_ops(input bit full_pred);
    for (int i = 0; i < 2*WORDS; i++) begin
      row_vec[32*i +: 32] = $urandom;
      col_vec[32*i +: 32] = $urandom;
    end
    for (int i = 0; i < WORDS; i++) begin
      row_pred[8*i +: 8] = full_pred ? 8'hFF : 8'($urandom);
      col_pred[8*i +: 8] = full_pred ? 8'hFF : 8'($urandom);
    end
  endtask

  task automatic run_op(input string tag, input bit rs, input bit cs, input bit ng, input bit wd, input bit poke);
    @(negedge clk);
    cur_tag = tag;
    mode_row_signed = rs; mode_col_signed = cs; mode_negate = ng; mode_wide = wd;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (poke) begin
      // R12: mode change and second start while busy
      repeat (3) @(negedge clk);
      mode_row_signed = ~rs; mode_col_signed = ~cs; mode_negate = ~ng; mode_wide = ~wd;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    repeat (NN + 4) @(negedge clk);
  endtask

  task automatic finish_report();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_report();
  end

  initial begin
    load_tile('0, 1'b1);
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1", "busy in reset", 64'(busy), 64'd0);
    check("R1", "done in reset", 64'(done), 64'd0);
    check("R1", "tile_rd_en in reset", 64'(tile_rd_en), 64'd0);
    check("R1", "tile_wr_en in reset", 64'(tile_wr_en), 64'd0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    rand_ops(1'b1);  run_op("R4", 1, 1, 0, 0, 0);
    rand_ops(1'b0);  run_op("R5", 1, 1, 0, 0, 0);
    rand_ops(1'b0);  run_op("R6", 0, 0, 0, 0, 0);
    rand_ops(1'b0);  run_op("R6", 1, 0, 0, 0, 0);
    rand_ops(1'b0);  run_op("R6", 0, 1, 0, 0, 0);
    rand_ops(1'b0);  run_op("R7", 1, 1, 1, 0, 0);
    rand_ops(1'b1);  run_op("R8", 1, 1, 0, 1, 0);
    rand_ops(1'b0);  run_op("R8", 0, 1, 1, 1, 0);
    rand_ops(1'b0);  run_op("R8", 1, 0, 0, 1, 0);

    // R9: wrap with all-ones operands into near-full accumulators
    load_tile(64'hFFFF_FFF0_FFFF_FFF0, 1'b0);
    row_vec = '1; col_vec = '1; row_pred = '1; col_pred = '1;
    run_op("R9", 0, 0, 0, 0, 0);
    load_tile(64'h0000_0001_0000_0000, 1'b0);
    run_op("R9", 0, 0, 1, 0, 0);
    load_tile(64'hFFFF_FFFF_FFFF_FFF0, 1'b0);
    run_op("R9", 0, 0, 0, 1, 0);

    // R10: every lane disabled
    load_tile('0, 1'b1);
    rand_ops(1'b0); row_pred = '0;
    run_op("R10", 1, 0, 1, 0, 0);
    rand_ops(1'b0); col_pred = {WORDS{8'hAA}}; row_pred = '1;
    run_op("R10", 1, 1, 0, 1, 0);

    // R12: start and mode changes during a pass are ignored
    rand_ops(1'b0);
    run_op("R12", 1, 0, 0, 0, 1);
    rand_ops(1'b0);
    run_op("R12", 0, 1, 1, 1, 1);

    finish_report();
  end
endmodule